// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block runs whole register-style transactions on an I2C bus by driving a bit-level master engine that sits below it. A request gives a 7-bit target address, a direction, a count of register-address bytes and a count of data bytes. The sequencer then issues the bus commands to the engine one at a time: open, address, register-address bytes, an optional reopen with a read address, data bytes, and close. The engine handles bit timing, clock stretching and line levels. This block only decides which command comes next and how each response is handled.

Register-address bytes and write data arrive on one valid/ready byte stream. For both directions the register-address bytes come first, and for a write the data bytes follow them. Read data leaves on a valid-qualified byte output. Each transaction ends with a one-cycle completion pulse. The pulse carries an ok flag and an error code that tells apart a rejected address, a rejected data byte and an engine fault. Any failure cuts the transaction short, and the bus is still closed with a stop.

Top module: `i2c_reg_xact`

## Requirements
- R1: The select byte sent after an open is the 7-bit target address in bits 7..1. Bit 0 is 0 for the write-direction select and 1 for the read-direction select.
- R2: A read with a non-zero data count issues these commands in order: open, write-select, each register-address byte, open again, read-select, one read per data byte, stop. The engine command codes are open=0, write byte=1, read byte=2, stop=3.
- R3: Every read command carries the reply bit `eng_cmd_nack`=0, except the final read of the transaction, which carries 1.
- R4: A write issues these commands in order: open, write-select, each register-address byte, each data byte, stop. The `ok` flag is 1 only if every byte is acknowledged and the stop reports no engine error.
- R5: If a select byte is not acknowledged, no further byte is sent. A stop follows, and the completion reports `ok`=0 with `err_code`=1.
- R6: If a register-address or write-data byte is not acknowledged, the remaining bytes are abandoned and are not taken from the stream. A stop follows, and the completion reports `ok`=0 with `err_code`=2.
- R7: An engine error on any command other than the stop aborts the transaction with a stop and `err_code`=3. A failing stop after an otherwise clean transaction also gives `err_code`=3. A failing stop after an earlier fault keeps the earlier code. A clean transaction reports `err_code`=0.
- R8: A read with a data count of zero sends the open, the write-select and the register-address bytes, and then stops with no second open.
- R9: Both byte counts are 16 bits wide, so transfers longer than 255 bytes complete in full.
- R10: `start` is accepted only while idle. `busy` is high from the cycle after acceptance until `done` pulses for one cycle, and `busy` is already low when `done` is high. A `start` seen while busy has no effect.
- R11: While `eng_cmd_valid` is high and `eng_cmd_ready` is low, the command fields stay unchanged. No new command is offered while a response is still outstanding.
- R12: Each read byte appears once on `rd_data` with `rd_valid` high, in bus order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| slave_addr | input | 7 | Target address |
| rd_mode | input | 1 | 1 = register read, 0 = write |
| reg_len | input | 16 | Number of register-address bytes |
| data_len | input | 16 | Number of data bytes to write or read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Completion status, valid with done |
| err_code | output | 2 | 0 none, 1 select NACK, 2 byte NACK, 3 engine error |
| wr_valid | input | 1 | Outgoing byte stream valid |
| wr_data | input | 8 | Outgoing byte (register address, then data) |
| wr_ready | output | 1 | Outgoing byte taken this cycle when valid |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| eng_cmd_valid | output | 1 | Command offered to the engine |
| eng_cmd_ready | input | 1 | Engine takes the command |
| eng_cmd_op | output | 2 | 0 open, 1 write byte, 2 read byte, 3 stop |
| eng_cmd_byte | output | 8 | Byte to write |
| eng_cmd_nack | output | 1 | Reply bit for a read: 1 = NACK |
| eng_rsp_valid | input | 1 | Engine finished the command |
| eng_rsp_nack | input | 1 | Written byte was not acknowledged |
| eng_rsp_err | input | 1 | Engine fault (bus busy, stretch timeout) |
| eng_rsp_byte | input | 8 | Byte read from the bus |

## Verification
The bench uses a model engine that stalls every other command, which catches a design that changes a command before the engine accepts it. A reply bit that is off by one shows up as a NACK on the wrong read, and a 300-byte read exposes a count that wraps at eight bits. Failures are injected on the select byte, on the first data byte, on the reopen and on the stop. These catch a design that keeps sending after an abort, that skips the closing stop, that pulls unsent bytes from the stream, or that lets a late stop fault overwrite the first error code. A zero-length read checks that no stray reopen is issued, and a second start pulse during a transaction checks that it is not taken as a new request.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    localparam int TGT_W  = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_SEL_NACK  = 2'd1,
        ERR_BYTE_NACK = 2'd2,
        ERR_ENGINE    = 2'd3
    } xact_err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPEN,
        ST_SEL_WR,
        ST_REGADR,
        ST_REOPEN,
        ST_SEL_RD,
        ST_RDATA,
        ST_WDATA,
        ST_CLOSE
    } seq_state_e;

    typedef struct packed {
        bus_op_e           op;
        logic [BYTE_W-1:0] data;
        logic              nack;
    } bus_cmd_t;

    typedef struct packed {
        logic              nack;
        logic              err;
        logic [BYTE_W-1:0] data;
    } bus_rsp_t;

    // Select byte: target address above the direction bit.
    function automatic logic [BYTE_W-1:0] sel_byte(input logic [TGT_W-1:0] tgt,
                                                   input logic rd);
        return {tgt, rd};
    endfunction

endpackage

// File: rtl/i2cseq_len_counter.sv
module i2cseq_len_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         empty,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - W'(1);
    end

    assign empty = (cnt_q == '0);
    assign last  = (cnt_q == W'(1));

    // R9: a byte is only consumed from a non-empty count
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (rst)
        dec |-> !empty);
endmodule

// File: rtl/i2cseq_cmd_port.sv
module i2cseq_cmd_port
    import i2cseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     issue,
    input  bus_cmd_t cmd_in,
    output logic     idle,
    output logic     eng_cmd_valid,
    input  logic     eng_cmd_ready,
    output bus_cmd_t eng_cmd,
    input  logic     eng_rsp_valid,
    input  bus_rsp_t rsp_in,
    output logic     fin,
    output bus_rsp_t fin_rsp
);
    typedef enum logic [1:0] {P_IDLE, P_REQ, P_WAIT} port_st_e;

    port_st_e pst_q;
    bus_cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pst_q <= P_IDLE;
            cmd_q <= '0;
        end else begin
            unique case (pst_q)
                P_IDLE: if (issue) begin
                    cmd_q <= cmd_in;
                    pst_q <= P_REQ;
                end
                P_REQ:  if (eng_cmd_ready) pst_q <= P_WAIT;
                P_WAIT: if (eng_rsp_valid) pst_q <= P_IDLE;
                default: pst_q <= P_IDLE;
            endcase
        end
    end

    assign idle          = (pst_q == P_IDLE);
    assign eng_cmd_valid = (pst_q == P_REQ);
    assign eng_cmd       = cmd_q;
    assign fin           = (pst_q == P_WAIT) && eng_rsp_valid;
    assign fin_rsp       = rsp_in;

    // R11: an offered command holds until taken
    a_r11_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (eng_cmd_valid && !eng_cmd_ready) |=> (eng_cmd_valid && $stable(eng_cmd)));
    // R11: the sequencer never issues over an outstanding command
    a_r11_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        issue |-> idle);
endmodule

// File: rtl/i2c_reg_xact.sv
module i2c_reg_xact
    import i2cseq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TGT_W-1:0]  slave_addr,
    input  logic              rd_mode,
    input  logic [LEN_W-1:0]  reg_len,
    input  logic [LEN_W-1:0]  data_len,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic [1:0]        err_code,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              eng_cmd_valid,
    input  logic              eng_cmd_ready,
    output logic [1:0]        eng_cmd_op,
    output logic [BYTE_W-1:0] eng_cmd_byte,
    output logic              eng_cmd_nack,
    input  logic              eng_rsp_valid,
    input  logic              eng_rsp_nack,
    input  logic              eng_rsp_err,
    input  logic [BYTE_W-1:0] eng_rsp_byte
);
    seq_state_e       state_q;
    xact_err_e        err_q;
    logic [TGT_W-1:0] tgt_q;
    logic             rd_q;

    logic     accept, port_idle, issue, fin;
    bus_cmd_t cmd_next, cmd_cur;
    bus_rsp_t rsp_in, rsp;
    logic     reg_empty, reg_last, dat_empty, dat_last;
    logic     reg_dec, dat_dec;

    assign accept = (state_q == ST_IDLE) && start;
    assign rsp_in = '{nack: eng_rsp_nack, err: eng_rsp_err, data: eng_rsp_byte};

    i2cseq_len_counter #(.W(LEN_W)) u_reg_cnt (
        .clk(clk), .rst(rst), .load(accept), .load_val(reg_len),
        .dec(reg_dec), .empty(reg_empty), .last(reg_last));

    i2cseq_len_counter #(.W(LEN_W)) u_dat_cnt (
        .clk(clk), .rst(rst), .load(accept), .load_val(data_len),
        .dec(dat_dec), .empty(dat_empty), .last(dat_last));

    i2cseq_cmd_port u_port (
        .clk(clk), .rst(rst), .issue(issue), .cmd_in(cmd_next),
        .idle(port_idle), .eng_cmd_valid(eng_cmd_valid),
        .eng_cmd_ready(eng_cmd_ready), .eng_cmd(cmd_cur),
        .eng_rsp_valid(eng_rsp_valid), .rsp_in(rsp_in),
        .fin(fin), .fin_rsp(rsp));

    assign eng_cmd_op   = cmd_cur.op;
    assign eng_cmd_byte = cmd_cur.data;
    assign eng_cmd_nack = cmd_cur.nack;

    assign reg_dec = fin && (state_q == ST_REGADR);
    assign dat_dec = fin && ((state_q == ST_RDATA) || (state_q == ST_WDATA));

    // Where to go once the register-address bytes are all sent.
    function automatic seq_state_e after_regs(input logic rd, input logic no_data);
        if (no_data) return ST_CLOSE;
        return rd ? ST_REOPEN : ST_WDATA;
    endfunction

    // Command selection for the current phase.
    always_comb begin
        issue    = 1'b0;
        wr_ready = 1'b0;
        cmd_next = '{op: OP_STOP, data: '0, nack: 1'b0};
        if (port_idle) begin
            unique case (state_q)
                ST_OPEN, ST_REOPEN: begin
                    issue       = 1'b1;
                    cmd_next.op = OP_START;
                end
                ST_SEL_WR, ST_SEL_RD: begin
                    issue         = 1'b1;
                    cmd_next.op   = OP_WRITE;
                    cmd_next.data = sel_byte(tgt_q, state_q == ST_SEL_RD);
                end
                ST_REGADR, ST_WDATA: begin
                    wr_ready      = 1'b1;
                    issue         = wr_valid;
                    cmd_next.op   = OP_WRITE;
                    cmd_next.data = wr_data;
                end
                ST_RDATA: begin
                    issue         = 1'b1;
                    cmd_next.op   = OP_READ;
                    cmd_next.nack = dat_last;
                end
                ST_CLOSE: begin
                    issue       = 1'b1;
                    cmd_next.op = OP_STOP;
                end
                default: ;
            endcase
        end
    end

    logic nack_checked;
    assign nack_checked = (state_q == ST_SEL_WR) || (state_q == ST_SEL_RD) ||
                          (state_q == ST_REGADR) || (state_q == ST_WDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            err_q    <= ERR_NONE;
            tgt_q    <= '0;
            rd_q     <= 1'b0;
            done     <= 1'b0;
            ok       <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            if (accept) begin
                tgt_q   <= slave_addr;
                rd_q    <= rd_mode;
                err_q   <= ERR_NONE;
                state_q <= ST_OPEN;
            end else if (fin) begin
                if (state_q == ST_CLOSE) begin
                    if (rsp.err && err_q == ERR_NONE) err_q <= ERR_ENGINE;
                    ok      <= !rsp.err && (err_q == ERR_NONE);
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end else if (rsp.err) begin
                    err_q   <= ERR_ENGINE;
                    state_q <= ST_CLOSE;
                end else if (nack_checked && rsp.nack) begin
                    err_q   <= (state_q == ST_SEL_WR || state_q == ST_SEL_RD)
                               ? ERR_SEL_NACK : ERR_BYTE_NACK;
                    state_q <= ST_CLOSE;
                end else begin
                    unique case (state_q)
                        ST_OPEN:   state_q <= ST_SEL_WR;
                        ST_SEL_WR: state_q <= reg_empty ? after_regs(rd_q, dat_empty)
                                                        : ST_REGADR;
                        ST_REGADR: if (reg_last) state_q <= after_regs(rd_q, dat_empty);
                        ST_REOPEN: state_q <= ST_SEL_RD;
                        ST_SEL_RD: state_q <= ST_RDATA;
                        ST_RDATA: begin
                            rd_valid <= 1'b1;
                            rd_data  <= rsp.data;
                            if (dat_last) state_q <= ST_CLOSE;
                        end
                        ST_WDATA:  if (dat_last) state_q <= ST_CLOSE;
                        default:   state_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign err_code = err_q;

    // R10: completion is reported only once the block is idle again
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R10: busy only rises from an accepted start
    a_r10_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    // R3: the reply bit marks exactly the final read
    a_r3_last_read_nack: assert property (@(posedge clk) disable iff (rst)
        (eng_cmd_valid && eng_cmd_op == OP_READ) |-> (eng_cmd_nack == dat_last));
    // R7: every completion follows a stop command
    a_r7_close_with_stop: assert property (@(posedge clk) disable iff (rst)
        done |-> (eng_cmd_op == OP_STOP));
    // R6: no stream byte is taken once a fault is recorded
    a_r6_no_pull_after_abort: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> (err_q == ERR_NONE));
    // R12: read bytes only appear inside a transaction
    a_r12_read_in_xact: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);
endmodule

// File: tb/i2c_reg_xact_test.sv
module i2c_reg_xact_test;
    localparam int PERIOD = 10;
    localparam int LOGN   = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(PERIOD/2) clk = ~clk;

    logic        start = 1'b0;
    logic [6:0]  slave_addr = '0;
    logic        rd_mode = 1'b0;
    logic [15:0] reg_len = '0, data_len = '0;
    logic        busy, done, ok, wr_ready, rd_valid;
    logic [1:0]  err_code;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0, rd_data;
    logic        eng_cmd_valid, eng_cmd_nack;
    logic        eng_cmd_ready = 1'b0;
    logic [1:0]  eng_cmd_op;
    logic [7:0]  eng_cmd_byte;
    logic        eng_rsp_valid = 1'b0, eng_rsp_nack = 1'b0, eng_rsp_err = 1'b0;
    logic [7:0]  eng_rsp_byte = '0;

    i2c_reg_xact uut (
        .clk(clk), .rst(rst), .start(start), .slave_addr(slave_addr),
        .rd_mode(rd_mode), .reg_len(reg_len), .data_len(data_len),
        .busy(busy), .done(done), .ok(ok), .err_code(err_code),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
        .eng_cmd_op(eng_cmd_op), .eng_cmd_byte(eng_cmd_byte),
        .eng_cmd_nack(eng_cmd_nack), .eng_rsp_valid(eng_rsp_valid),
        .eng_rsp_nack(eng_rsp_nack), .eng_rsp_err(eng_rsp_err),
        .eng_rsp_byte(eng_rsp_byte));

    int checks = 0, errors = 0;

    // model engine, stream source and monitors
    logic [1:0] log_op [LOGN];
    logic [7:0] log_b  [LOGN];
    logic       log_n  [LOGN];
    logic [7:0] rd_buf [LOGN];
    logic [7:0] src    [16];
    int ncmd = 0, nrd = 0, src_n = 0, ptr = 0, model_rd = 0;
    int nack_idx = -1, err_idx = -1;
    int done_cnt = 0, proto_err = 0, phase = 0;
    logic hs_pend = 1'b0, stalled = 1'b0, cap_ok = 1'b0;
    logic [1:0] cap_code = '0, st_op = '0;
    logic [7:0] st_b = '0;

    always @(negedge clk) begin
        if (hs_pend) ptr++;
        wr_valid = (ptr < src_n);
        wr_data  = src[ptr % 16];
        hs_pend  = wr_valid && wr_ready;

        if (rd_valid) begin rd_buf[nrd % LOGN] = rd_data; nrd++; end
        if (done) begin done_cnt++; cap_ok = ok; cap_code = err_code; end

        if ((phase == 1 || phase == 3) && eng_cmd_valid) proto_err++;
        case (phase)
            0: if (eng_cmd_valid) begin
                if (ncmd % 2 == 1 && !stalled) begin
                    stalled = 1'b1; st_op = eng_cmd_op; st_b = eng_cmd_byte;
                    eng_cmd_ready = 1'b0;
                end else begin
                    if (stalled && (st_op != eng_cmd_op || st_b != eng_cmd_byte))
                        proto_err++;
                    stalled = 1'b0;
                    log_op[ncmd % LOGN] = eng_cmd_op;
                    log_b[ncmd % LOGN]  = eng_cmd_byte;
                    log_n[ncmd % LOGN]  = eng_cmd_nack;
                    eng_cmd_ready = 1'b1;
                    phase = 1;
                end
            end
            1: begin
                eng_cmd_ready = 1'b0;
                eng_rsp_valid = 1'b1;
                eng_rsp_nack  = (ncmd == nack_idx);
                eng_rsp_err   = (ncmd == err_idx);
                eng_rsp_byte  = 8'(8'hA0 + model_rd);
                if (log_op[ncmd % LOGN] == 2'd2) model_rd++;
                ncmd++;
                phase = 3;
            end
            3: begin
                eng_rsp_valid = 1'b0;
                eng_rsp_nack  = 1'b0;
                eng_rsp_err   = 1'b0;
                phase = 0;
            end
            default: phase = 0;
        endcase
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_cmd(string req, int i, int op, int b, int n);
        chk(req, $sformatf("cmd%0d op", i), int'(log_op[i]), op);
        if (op == 1) chk(req, $sformatf("cmd%0d byte", i), int'(log_b[i]), b);
        if (op == 2) chk(req, $sformatf("cmd%0d reply", i), int'(log_n[i]), n);
    endtask

    task automatic setup(int n_idx, int e_idx, int n_src);
        @(negedge clk);
        ncmd = 0; nrd = 0; model_rd = 0; ptr = 0; hs_pend = 1'b0;
        nack_idx = n_idx; err_idx = e_idx; src_n = n_src;
        for (int i = 0; i < 16; i++) src[i] = 8'(8'h10 + i);
    endtask

    task automatic run(logic [6:0] a, logic rd, int rl, int dl);
        int d0;
        int t;
        d0 = done_cnt;
        slave_addr = a; rd_mode = rd; reg_len = 16'(rl); data_len = 16'(dl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (done_cnt == d0 && t < 20000) begin @(negedge clk); t++; end
        if (done_cnt == d0) chk("R10", "completion timeout", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10", "busy after reset", int'(busy), 0);
        chk("R10", "done after reset", int'(done), 0);
        chk("R11", "cmd_valid after reset", int'(eng_cmd_valid), 0);
        chk("R12", "rd_valid after reset", int'(rd_valid), 0);
        chk("R6", "wr_ready after reset", int'(wr_ready), 0);
    endtask

    task automatic t_reg_read();
        setup(-1, -1, 2);
        run(7'h50, 1'b1, 2, 3);
        chk("R2", "command count", ncmd, 10);
        chk_cmd("R2", 0, 0, 0, 0);
        chk_cmd("R1", 1, 1, 8'hA0, 0);
        chk_cmd("R2", 2, 1, 8'h10, 0);
        chk_cmd("R2", 3, 1, 8'h11, 0);
        chk_cmd("R2", 4, 0, 0, 0);
        chk_cmd("R1", 5, 1, 8'hA1, 0);
        chk_cmd("R3", 6, 2, 0, 0);
        chk_cmd("R3", 7, 2, 0, 0);
        chk_cmd("R3", 8, 2, 0, 1);
        chk_cmd("R2", 9, 3, 0, 0);
        chk("R12", "read count", nrd, 3);
        for (int i = 0; i < 3; i++) chk("R12", "read byte", int'(rd_buf[i]), 8'hA0 + i);
        chk("R4", "ok", int'(cap_ok), 1);
        chk("R7", "code clean", int'(cap_code), 0);
        chk("R11", "hold/outstanding violations", proto_err, 0);
    endtask

    task automatic t_write();
        setup(-1, -1, 3);
        run(7'h3C, 1'b0, 1, 2);
        chk("R4", "command count", ncmd, 6);
        chk_cmd("R4", 0, 0, 0, 0);
        chk_cmd("R1", 1, 1, 8'h78, 0);
        chk_cmd("R4", 2, 1, 8'h10, 0);
        chk_cmd("R4", 3, 1, 8'h11, 0);
        chk_cmd("R4", 4, 1, 8'h12, 0);
        chk_cmd("R4", 5, 3, 0, 0);
        chk("R4", "ok", int'(cap_ok), 1);
        chk("R4", "stream bytes taken", ptr, 3);
    endtask

    task automatic t_zero_read();
        setup(-1, -1, 1);
        run(7'h21, 1'b1, 1, 0);
        chk("R8", "command count", ncmd, 4);
        chk_cmd("R8", 2, 1, 8'h10, 0);
        chk_cmd("R8", 3, 3, 0, 0);
        chk("R8", "no read bytes", nrd, 0);
        chk("R8", "ok", int'(cap_ok), 1);
    endtask

    task automatic t_sel_nack();
        setup(1, -1, 3);
        run(7'h11, 1'b0, 1, 2);
        chk("R5", "command count", ncmd, 3);
        chk_cmd("R5", 2, 3, 0, 0);
        chk("R5", "ok", int'(cap_ok), 0);
        chk("R5", "code", int'(cap_code), 1);
        chk("R6", "stream untouched", ptr, 0);
    endtask

    task automatic t_data_nack();
        setup(3, -1, 4);
        run(7'h11, 1'b0, 1, 3);
        chk("R6", "command count", ncmd, 5);
        chk_cmd("R6", 3, 1, 8'h11, 0);
        chk_cmd("R6", 4, 3, 0, 0);
        chk("R6", "ok", int'(cap_ok), 0);
        chk("R6", "code", int'(cap_code), 2);
        chk("R6", "stream bytes taken", ptr, 2);
    endtask

    task automatic t_reopen_err();
        setup(-1, 3, 1);
        run(7'h42, 1'b1, 1, 2);
        chk("R7", "command count", ncmd, 5);
        chk_cmd("R7", 3, 0, 0, 0);
        chk_cmd("R7", 4, 3, 0, 0);
        chk("R7", "code", int'(cap_code), 3);
        chk("R7", "no read bytes", nrd, 0);
    endtask

    task automatic t_stop_err();
        setup(-1, 3, 1);
        run(7'h42, 1'b0, 0, 1);
        chk("R4", "command count", ncmd, 4);
        chk("R4", "ok with failing stop", int'(cap_ok), 0);
        chk("R7", "code with failing stop", int'(cap_code), 3);
    endtask

    task automatic t_nack_then_stop_err();
        setup(1, 2, 1);
        run(7'h42, 1'b0, 0, 1);
        chk("R7", "first code kept", int'(cap_code), 1);
        chk("R7", "ok", int'(cap_ok), 0);
    endtask

    task automatic t_busy_start();
        int d0;
        setup(-1, -1, 1);
        d0 = done_cnt;
        run_bg();
        chk("R10", "single completion", done_cnt - d0, 1);
        chk("R10", "command count", ncmd, 4);
        chk_cmd("R10", 1, 1, 8'h66, 0);
    endtask

    task automatic run_bg();
        int t;
        slave_addr = 7'h33; rd_mode = 1'b0; reg_len = 16'd0; data_len = 16'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", "busy mid transaction", int'(busy), 1);
        slave_addr = 7'h7F; rd_mode = 1'b1; data_len = 16'd5;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (busy && t < 2000) begin @(negedge clk); t++; end
        repeat (30) @(negedge clk);
        chk("R10", "idle after completion", int'(busy), 0);
    endtask

    task automatic t_long_read();
        int bad;
        setup(-1, -1, 0);
        run(7'h05, 1'b1, 0, 300);
        chk("R9", "command count", ncmd, 305);
        chk("R9", "read count", nrd, 300);
        bad = 0;
        for (int i = 0; i < 300; i++) if (rd_buf[i] != 8'(8'hA0 + i)) bad++;
        chk("R12", "read order mismatches", bad, 0);
        chk_cmd("R3", 302, 2, 0, 0);
        chk_cmd("R3", 303, 2, 0, 1);
        chk("R9", "ok", int'(cap_ok), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reg_read();
        t_write();
        t_zero_read();
        t_sel_nack();
        t_data_nack();
        t_reopen_err();
        t_stop_err();
        t_nack_then_stop_err();
        t_busy_start();
        t_long_read();
        chk("R11", "hold/outstanding violations overall", proto_err, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(negedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule